// File: doc/BRIEF.md
# Transactional Cache Line Controller

This block keeps the per-line state of a small direct-mapped data cache that takes part in hardware transactional memory. Besides its coherence state (invalid, clean or dirty), every line carries a transactional tag and a speculative-write mark. While a transaction is open, every load or store the core issues tags the line it touches. A store also marks the line as speculative, and the value that stood before the store stays safe in the level below.

An invalidating snoop from another agent that hits a tagged line is a conflict, and so is a miss that would have to evict a tagged line. Either one ends the transaction as aborted. When the transaction ends, every tag is dropped at the same clock edge. A commit turns the speculative lines into dirty lines. An abort throws those lines away and keeps the lines that were only read. The core drives one request per cycle together with begin, commit and abort strobes. A two-bit status output tells it how the last transaction ended. Dirty data that leaves the cache appears on a write-back port, or on a snoop data port when a snoop asks for it.

Top module: `txcache_ctrl`

## Requirements
- R1: After reset the status is idle (code 0), every line is invalid (so the first read of any address returns `fill_data`), and `rsp_valid`, `wb_valid` and `snp_dirty` are low.
- R2: An address splits into a line index (bits 2:0) and a tag (bits 7:3). A read that misses returns `fill_data` and allocates the line. A read that hits returns the stored word. `rsp_valid` and `rsp_data` appear one cycle after the request.
- R3: A store outside a transaction leaves the line dirty. A dirty line replaced by a miss appears one cycle later on `wb_valid`/`wb_addr`/`wb_data` with its own address and data. An invalidating snoop that hits a dirty line returns its data on `snp_data` with `snp_dirty`, and leaves the line invalid.
- R4: Status codes are: 0 idle, 1 active, 2 committed, 3 aborted. `txn_begin` outside an active transaction makes the status active one cycle later. A request in the begin cycle is not transactional.
- R5: A commit makes the status committed. Lines that the transaction only read stay resident and hold their data.
- R6: At commit, speculatively written lines become dirty. A transactional store to a line that was already dirty first writes the old value back on the write-back port.
- R7: `txn_abort` during a transaction makes the status aborted. Speculatively written lines become invalid. Lines that were only read stay resident.
- R8: An invalidating snoop that hits a tagged line aborts the transaction and leaves that line invalid. Speculative data is never returned on `snp_data`, but a dirty line that was only read is returned.
- R9: While a transaction is active, a snoop that hits no tagged line does not abort it. It still invalidates any untagged line it hits.
- R10: A miss whose index holds a tagged line aborts the transaction. A request in any cycle where the transaction aborts is dropped: it gets no response and allocates nothing.
- R11: Tags clear at the same edge as the commit or abort. Abort wins over a commit in the same cycle. Commit and abort are ignored when no transaction is active, and begin is ignored while one is active.
- R12: A read inside a transaction of a line that the same transaction stored returns the stored value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| txn_begin | input | 1 | Open a transaction |
| txn_commit | input | 1 | Commit the open transaction |
| txn_abort | input | 1 | Abort the open transaction |
| req_valid | input | 1 | Core request strobe |
| req_write | input | 1 | 1 = store, 0 = load |
| req_addr | input | 8 | Word address: tag and line index |
| req_wdata | input | 32 | Store data |
| fill_data | input | 32 | Word from the level below, used on a miss |
| snp_valid | input | 1 | Invalidating snoop strobe |
| snp_addr | input | 8 | Snooped address |
| rsp_valid | output | 1 | Load response strobe |
| rsp_data | output | 32 | Load response data |
| wb_valid | output | 1 | Write-back strobe |
| wb_addr | output | 8 | Write-back address |
| wb_data | output | 32 | Write-back data |
| snp_dirty | output | 1 | Snoop hit a non-speculative dirty line |
| snp_data | output | 32 | Data returned to the snoop |
| txn_status | output | 2 | Transaction status code |

## Verification
The hardest states to reach are the ones where several things happen in the same cycle. Examples are a snoop that conflicts in the very cycle a load is presented, a commit and an abort together, and a miss that maps onto a line the transaction already tagged. The stimulus reaches them with staged sequences. Each sequence first fills chosen indices with known tags and with clean, dirty or speculative contents, then fires the colliding events in one cycle. A later read with a distinctive `fill_data` word then shows whether each line survived: a hit returns the old word and a miss returns the new one. A snoop or an eviction shows whether the line is dirty.

// File: rtl/txc_pkg.sv
package txc_pkg;

  typedef enum logic [1:0] {
    TS_IDLE      = 2'd0,
    TS_ACTIVE    = 2'd1,
    TS_COMMITTED = 2'd2,
    TS_ABORTED   = 2'd3
  } txn_status_e;

  typedef enum logic [1:0] {
    LS_INV   = 2'd0,
    LS_CLEAN = 2'd1,
    LS_DIRTY = 2'd2
  } line_state_e;

endpackage

// File: rtl/txc_line.sv
module txc_line
  import txc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int TAG_W  = 5
) (
  input  logic              clk,
  input  logic              rst_ni,
  input  logic              snp_kill,
  input  logic              abort_i,
  input  logic              commit_i,
  input  logic              req_sel,
  input  logic              req_miss,
  input  logic              req_wr,
  input  logic              req_tx,
  input  logic [TAG_W-1:0]  tag_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [DATA_W-1:0] fill_i,
  output logic [1:0]        state_o,
  output logic              tx_o,
  output logic              spec_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [DATA_W-1:0] data_o
);

  line_state_e       st_q, st_d;
  logic              tx_q, tx_d;
  logic              sp_q, sp_d;
  logic [TAG_W-1:0]  tag_q, tag_d;
  logic [DATA_W-1:0] dat_q, dat_d;
  logic              upd;

  assign upd = snp_kill | abort_i | commit_i | req_sel;

  always_comb begin
    st_d  = st_q;
    tx_d  = tx_q;
    sp_d  = sp_q;
    tag_d = tag_q;
    dat_d = dat_q;
    if (abort_i) begin
      // discard speculative contents; read-only lines just lose the tag
      if (sp_q || snp_kill) st_d = LS_INV;
      tx_d = 1'b0;
      sp_d = 1'b0;
    end else begin
      if (snp_kill) begin
        st_d = LS_INV;
        tx_d = 1'b0;
        sp_d = 1'b0;
      end
      if (req_sel) begin
        if (req_miss) begin
          st_d  = LS_CLEAN;
          tag_d = tag_i;
          dat_d = fill_i;
          tx_d  = 1'b0;
          sp_d  = 1'b0;
        end
        if (req_tx) tx_d = 1'b1;
        if (req_wr) begin
          dat_d = wdata_i;
          if (req_tx) begin
            sp_d = 1'b1;
            st_d = LS_CLEAN;   // old dirty value already sent below
          end else begin
            st_d = LS_DIRTY;
          end
        end
      end
      if (commit_i) begin
        if (sp_d) st_d = LS_DIRTY;
        tx_d = 1'b0;
        sp_d = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= LS_INV;
      tx_q <= 1'b0;
      sp_q <= 1'b0;
    end else if (upd) begin
      st_q <= st_d;
      tx_q <= tx_d;
      sp_q <= sp_d;
    end
  end

  always_ff @(posedge clk) begin
    if (upd) begin
      tag_q <= tag_d;
      dat_q <= dat_d;
    end
  end

  assign state_o = st_q;
  assign tx_o    = tx_q;
  assign spec_o  = sp_q;
  assign tag_o   = tag_q;
  assign data_o  = dat_q;

endmodule

// File: rtl/txc_lookup.sv
module txc_lookup
  import txc_pkg::*;
#(
  parameter int NLINES = 8,
  parameter int TAG_W  = 5,
  parameter int IDX_W  = 3
) (
  input  logic [NLINES-1:0][1:0]       ln_state,
  input  logic [NLINES-1:0][TAG_W-1:0] ln_tag,
  input  logic [NLINES-1:0]            ln_tx,
  input  logic [NLINES-1:0]            ln_spec,
  input  logic                         snp_valid,
  input  logic [IDX_W-1:0]             snp_idx,
  input  logic [TAG_W-1:0]             snp_tag,
  input  logic [IDX_W-1:0]             req_idx,
  input  logic [TAG_W-1:0]             req_tag,
  output logic [NLINES-1:0]            snp_kill,
  output logic                         snp_conflict,
  output logic                         snp_give,
  output logic                         req_hit,
  output logic                         req_tx_line,
  output logic                         req_dirty_ns
);

  logic [NLINES-1:0] live;
  logic [NLINES-1:0] dirty_ns;

  for (genvar i = 0; i < NLINES; i++) begin : g_cmp
    assign live[i]     = (ln_state[i] != LS_INV);
    assign dirty_ns[i] = (ln_state[i] == LS_DIRTY) && !ln_spec[i];
    assign snp_kill[i] = snp_valid && live[i] &&
                         (snp_idx == IDX_W'(i)) && (ln_tag[i] == snp_tag);
  end

  logic req_live;

  always_comb begin
    snp_conflict = |(snp_kill & ln_tx);
    snp_give     = |(snp_kill & dirty_ns);
    // request sees the line as it stands after this cycle's snoop
    req_live     = live[req_idx] && !snp_kill[req_idx];
    req_hit      = req_live && (ln_tag[req_idx] == req_tag);
    req_tx_line  = req_live && ln_tx[req_idx];
    req_dirty_ns = req_live && dirty_ns[req_idx];
  end

endmodule

// File: rtl/txc_txn_fsm.sv
module txc_txn_fsm
  import txc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_ni,
  input  logic       begin_i,
  input  logic       commit_i,
  input  logic       abort_i,
  input  logic       conflict_i,
  output logic [1:0] status_o,
  output logic       active_o,
  output logic       do_commit_o,
  output logic       do_abort_o
);

  txn_status_e st_q, st_d;
  logic        st_en;

  assign active_o = (st_q == TS_ACTIVE);

  always_comb begin
    do_abort_o  = active_o && (abort_i || conflict_i);
    do_commit_o = active_o && commit_i && !do_abort_o;
    st_d = st_q;
    if (do_abort_o)                 st_d = TS_ABORTED;
    else if (do_commit_o)           st_d = TS_COMMITTED;
    else if (begin_i && !active_o)  st_d = TS_ACTIVE;
    st_en = (st_d != st_q);
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)    st_q <= TS_IDLE;
    else if (st_en) st_q <= st_d;
  end

  assign status_o = st_q;

endmodule

// File: rtl/txcache_ctrl.sv
module txcache_ctrl
  import txc_pkg::*;
#(
  parameter int NLINES = 8,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              txn_begin,
  input  logic              txn_commit,
  input  logic              txn_abort,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic [DATA_W-1:0] fill_data,
  input  logic              snp_valid,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              wb_valid,
  output logic [ADDR_W-1:0] wb_addr,
  output logic [DATA_W-1:0] wb_data,
  output logic              snp_dirty,
  output logic [DATA_W-1:0] snp_data,
  output logic [1:0]        txn_status
);

  localparam int IDX_W = $clog2(NLINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  // reset: asserted at once, released after two clock edges
  logic [1:0] rst_pipe;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_ni = rst_pipe[1];

  logic [IDX_W-1:0] req_idx, snp_idx;
  logic [TAG_W-1:0] req_tag, snp_tag;
  assign req_idx = req_addr[IDX_W-1:0];
  assign req_tag = req_addr[ADDR_W-1:IDX_W];
  assign snp_idx = snp_addr[IDX_W-1:0];
  assign snp_tag = snp_addr[ADDR_W-1:IDX_W];

  logic [NLINES-1:0][1:0]        ln_state;
  logic [NLINES-1:0][TAG_W-1:0]  ln_tag;
  logic [NLINES-1:0][DATA_W-1:0] ln_data;
  logic [NLINES-1:0]             ln_tx, ln_spec;

  logic [NLINES-1:0] snp_kill;
  logic snp_conflict, snp_give, req_hit, req_tx_line, req_dirty_ns;

  txc_lookup #(.NLINES(NLINES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_lookup (
    .ln_state    (ln_state),
    .ln_tag      (ln_tag),
    .ln_tx       (ln_tx),
    .ln_spec     (ln_spec),
    .snp_valid   (snp_valid),
    .snp_idx     (snp_idx),
    .snp_tag     (snp_tag),
    .req_idx     (req_idx),
    .req_tag     (req_tag),
    .snp_kill    (snp_kill),
    .snp_conflict(snp_conflict),
    .snp_give    (snp_give),
    .req_hit     (req_hit),
    .req_tx_line (req_tx_line),
    .req_dirty_ns(req_dirty_ns)
  );

  logic evict_conflict, active, do_commit, do_abort, req_go;
  assign evict_conflict = req_valid && !req_hit && req_tx_line;

  txc_txn_fsm u_fsm (
    .clk        (clk),
    .rst_ni     (rst_ni),
    .begin_i    (txn_begin),
    .commit_i   (txn_commit),
    .abort_i    (txn_abort),
    .conflict_i (snp_conflict || evict_conflict),
    .status_o   (txn_status),
    .active_o   (active),
    .do_commit_o(do_commit),
    .do_abort_o (do_abort)
  );

  assign req_go = req_valid && !do_abort;

  for (genvar i = 0; i < NLINES; i++) begin : g_line
    txc_line #(.DATA_W(DATA_W), .TAG_W(TAG_W)) u_line (
      .clk     (clk),
      .rst_ni  (rst_ni),
      .snp_kill(snp_kill[i]),
      .abort_i (do_abort),
      .commit_i(do_commit),
      .req_sel (req_go && (req_idx == IDX_W'(i))),
      .req_miss(!req_hit),
      .req_wr  (req_write),
      .req_tx  (active),
      .tag_i   (req_tag),
      .wdata_i (req_wdata),
      .fill_i  (fill_data),
      .state_o (ln_state[i]),
      .tx_o    (ln_tx[i]),
      .spec_o  (ln_spec[i]),
      .tag_o   (ln_tag[i]),
      .data_o  (ln_data[i])
    );
  end

  // next values of the registered outputs
  logic              rsp_v_d, wb_v_d, snp_v_d;
  logic [DATA_W-1:0] rsp_d_d, wb_d_d, snp_d_d;
  logic [ADDR_W-1:0] wb_a_d;

  always_comb begin
    rsp_v_d = req_go && !req_write;
    rsp_d_d = req_hit ? ln_data[req_idx] : fill_data;
    wb_v_d  = req_go && req_dirty_ns && (!req_hit || (req_write && active));
    wb_a_d  = {ln_tag[req_idx], req_idx};
    wb_d_d  = ln_data[req_idx];
    snp_v_d = snp_give;
    snp_d_d = ln_data[snp_idx];
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid <= 1'b0;
      wb_valid  <= 1'b0;
      snp_dirty <= 1'b0;
    end else begin
      rsp_valid <= rsp_v_d;
      wb_valid  <= wb_v_d;
      snp_dirty <= snp_v_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rsp_v_d) rsp_data <= rsp_d_d;
    if (wb_v_d) begin
      wb_addr <= wb_a_d;
      wb_data <= wb_d_d;
    end
    if (snp_v_d) snp_data <= snp_d_d;
  end

endmodule

// File: rtl/txcache_ctrl_chk.sv
module txcache_ctrl_chk
  import txc_pkg::*;
#(
  parameter int NLINES = 8
) (
  input logic              clk,
  input logic              rst_ni,
  input logic [1:0]        status,
  input logic              txn_begin,
  input logic              txn_commit,
  input logic              txn_abort,
  input logic              req_valid,
  input logic              req_write,
  input logic              rsp_valid,
  input logic              snp_valid,
  input logic [NLINES-1:0] snp_kill,
  input logic [NLINES-1:0] line_tx,
  input logic [NLINES-1:0] line_spec
);

  assert_rsp_source_R2: assert property (@(posedge clk) disable iff (!rst_ni)
    rsp_valid |-> $past(req_valid && !req_write));

  assert_no_tag_outside_R4: assert property (@(posedge clk) disable iff (!rst_ni)
    (status != TS_ACTIVE) |-> (line_tx == '0));

  assert_spec_tagged_R6: assert property (@(posedge clk) disable iff (!rst_ni)
    (line_spec & ~line_tx) == '0);

  assert_commit_clears_R5: assert property (@(posedge clk) disable iff (!rst_ni)
    (status == TS_ACTIVE && txn_commit) |=>
      (line_tx == '0) && (status == TS_COMMITTED || status == TS_ABORTED));

  assert_abort_discards_R7: assert property (@(posedge clk) disable iff (!rst_ni)
    (status == TS_ACTIVE && txn_abort) |=>
      (status == TS_ABORTED) && (line_tx == '0) && (line_spec == '0));

  assert_snoop_conflict_R8: assert property (@(posedge clk) disable iff (!rst_ni)
    (status == TS_ACTIVE && snp_valid && |(snp_kill & line_tx)) |=> (status == TS_ABORTED));

  assert_drop_on_abort_R10: assert property (@(posedge clk) disable iff (!rst_ni)
    (status == TS_ACTIVE && txn_abort && req_valid) |=> !rsp_valid);

  assert_ignore_strobes_R11: assert property (@(posedge clk) disable iff (!rst_ni)
    (status != TS_ACTIVE && !txn_begin) |=> $stable(status));

endmodule

bind txcache_ctrl txcache_ctrl_chk #(.NLINES(NLINES)) u_chk (
  .clk       (clk),
  .rst_ni    (rst_ni),
  .status    (txn_status),
  .txn_begin (txn_begin),
  .txn_commit(txn_commit),
  .txn_abort (txn_abort),
  .req_valid (req_valid),
  .req_write (req_write),
  .rsp_valid (rsp_valid),
  .snp_valid (snp_valid),
  .snp_kill  (snp_kill),
  .line_tx   (ln_tx),
  .line_spec (ln_spec)
);

// File: tb/txcache_ctrl_tb.sv
module txcache_ctrl_tb;

  localparam logic [1:0] ST_IDLE = 2'd0;
  localparam logic [1:0] ST_ACT  = 2'd1;
  localparam logic [1:0] ST_CMT  = 2'd2;
  localparam logic [1:0] ST_ABT  = 2'd3;

  logic clk = 1'b0;
  always #5ns clk = ~clk;

  logic        rst_n;
  logic        txn_begin, txn_commit, txn_abort;
  logic        req_valid, req_write;
  logic [7:0]  req_addr;
  logic [31:0] req_wdata, fill_data;
  logic        snp_valid;
  logic [7:0]  snp_addr;
  logic        rsp_valid, wb_valid, snp_dirty;
  logic [31:0] rsp_data, wb_data, snp_data;
  logic [7:0]  wb_addr;
  logic [1:0]  txn_status;

  txcache_ctrl u_dut (
    .clk(clk), .rst_n(rst_n),
    .txn_begin(txn_begin), .txn_commit(txn_commit), .txn_abort(txn_abort),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .fill_data(fill_data),
    .snp_valid(snp_valid), .snp_addr(snp_addr),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data),
    .snp_dirty(snp_dirty), .snp_data(snp_data),
    .txn_status(txn_status)
  );

  typedef struct packed {
    logic        rv, rw;
    logic [7:0]  ra;
    logic [31:0] wd, fd;
    logic        b, c, a, sv;
    logic [7:0]  sa;
  } stim_t;

  typedef struct packed {
    logic        rv;
    logic [31:0] rd;
    logic        wv;
    logic [7:0]  wa;
    logic [31:0] wd;
    logic        sv;
    logic [31:0] sd;
    logic [1:0]  st;
  } exp_t;

  typedef struct {
    exp_t  e;
    string tag;
    int    stamp;
  } item_t;

  item_t q[$];
  int    cyc = 0;
  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic stim_t s0();
    return '0;
  endfunction
  function automatic stim_t s_rd(logic [7:0] a, logic [31:0] f);
    stim_t s = '0; s.rv = 1; s.ra = a; s.fd = f; return s;
  endfunction
  function automatic stim_t s_wr(logic [7:0] a, logic [31:0] d);
    stim_t s = '0; s.rv = 1; s.rw = 1; s.ra = a; s.wd = d; s.fd = 32'hDEAD_0000; return s;
  endfunction
  function automatic stim_t s_snp(logic [7:0] a);
    stim_t s = '0; s.sv = 1; s.sa = a; return s;
  endfunction
  function automatic stim_t s_beg();
    stim_t s = '0; s.b = 1; return s;
  endfunction
  function automatic stim_t s_cmt();
    stim_t s = '0; s.c = 1; return s;
  endfunction
  function automatic stim_t s_abt();
    stim_t s = '0; s.a = 1; return s;
  endfunction

  function automatic exp_t e_no(logic [1:0] st);
    exp_t e = '0; e.st = st; return e;
  endfunction
  function automatic exp_t e_rsp(logic [1:0] st, logic [31:0] d);
    exp_t e = '0; e.st = st; e.rv = 1; e.rd = d; return e;
  endfunction
  function automatic exp_t e_wb(logic [1:0] st, logic [7:0] a, logic [31:0] d);
    exp_t e = '0; e.st = st; e.wv = 1; e.wa = a; e.wd = d; return e;
  endfunction
  function automatic exp_t e_snp(logic [1:0] st, logic [31:0] d);
    exp_t e = '0; e.st = st; e.sv = 1; e.sd = d; return e;
  endfunction

  // driver: applies one cycle of stimulus and queues what it must produce
  task automatic go(stim_t s, exp_t e, string tag);
    item_t it;
    @(negedge clk);
    req_valid  = s.rv;  req_write = s.rw; req_addr = s.ra;
    req_wdata  = s.wd;  fill_data = s.fd;
    txn_begin  = s.b;   txn_commit = s.c; txn_abort = s.a;
    snp_valid  = s.sv;  snp_addr  = s.sa;
    it.e = e; it.tag = tag; it.stamp = cyc;
    q.push_back(it);
  endtask

  // monitor: compares one cycle after each driven cycle
  always @(negedge clk) begin
    if (q.size() > 0 && q[0].stamp == cyc - 1) begin
      item_t it;
      bit    bad;
      it  = q.pop_front();
      bad = (rsp_valid !== it.e.rv) || (it.e.rv && rsp_data !== it.e.rd) ||
            (wb_valid !== it.e.wv) || (it.e.wv && (wb_addr !== it.e.wa || wb_data !== it.e.wd)) ||
            (snp_dirty !== it.e.sv) || (it.e.sv && snp_data !== it.e.sd) ||
            (txn_status !== it.e.st);
      n_cmp++;
      if (bad) begin
        n_bad++;
        $display("FAIL %s cyc=%0d actual st=%0d rsp=%b/%h wb=%b/%h/%h snp=%b/%h expected st=%0d rsp=%b/%h wb=%b/%h/%h snp=%b/%h",
                 it.tag, cyc, txn_status, rsp_valid, rsp_data, wb_valid, wb_addr, wb_data,
                 snp_dirty, snp_data, it.e.st, it.e.rv, it.e.rd, it.e.wv, it.e.wa, it.e.wd,
                 it.e.sv, it.e.sd);
      end
    end
  end

  initial begin
    rst_n = 1'b0;
    req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0; fill_data = 0;
    txn_begin = 0; txn_commit = 0; txn_abort = 0; snp_valid = 0; snp_addr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1: reset state; commit/abort while idle ignored (R11)
    go(s0(), e_no(ST_IDLE), "R1");
    go(s_cmt(), e_no(ST_IDLE), "R11");
    go(s_abt(), e_no(ST_IDLE), "R11");
    go(s_rd(8'h08, 32'hA100_0008), e_rsp(ST_IDLE, 32'hA100_0008), "R1");
    // R2: hit returns stored word
    go(s_rd(8'h08, 32'hFFFF_FFFF), e_rsp(ST_IDLE, 32'hA100_0008), "R2");
    // R3: dirty line displaced by a miss is written back
    go(s_wr(8'h08, 32'hD100_0001), e_no(ST_IDLE), "R3");
    begin
      exp_t e = e_rsp(ST_IDLE, 32'hB100_0010);
      e.wv = 1; e.wa = 8'h08; e.wd = 32'hD100_0001;
      go(s_rd(8'h10, 32'hB100_0010), e, "R3");
    end
    // snoop on clean line: no data, line gone
    go(s_snp(8'h10), e_no(ST_IDLE), "R9");
    go(s_rd(8'h10, 32'hC100_0010), e_rsp(ST_IDLE, 32'hC100_0010), "R9");
    // snoop on dirty line returns data and invalidates
    go(s_wr(8'h11, 32'hD200_0002), e_no(ST_IDLE), "R3");
    go(s_snp(8'h11), e_snp(ST_IDLE, 32'hD200_0002), "R3");
    go(s_rd(8'h11, 32'hE100_0011), e_rsp(ST_IDLE, 32'hE100_0011), "R3");

    // transaction 1: commit
    go(stim_t'(s_beg() | s_wr(8'h12, 32'hD300_0003)), e_no(ST_ACT), "R4");
    go(s_rd(8'h10, 32'hFFFF_FFFF), e_rsp(ST_ACT, 32'hC100_0010), "R5");
    go(s_wr(8'h12, 32'hD400_0004), e_wb(ST_ACT, 8'h12, 32'hD300_0003), "R6");
    go(s_rd(8'h12, 32'h0), e_rsp(ST_ACT, 32'hD400_0004), "R12");
    go(s_snp(8'h13), e_no(ST_ACT), "R9");
    go(s_snp(8'h11), e_no(ST_ACT), "R9");
    go(s_cmt(), e_no(ST_CMT), "R5");
    go(s_snp(8'h12), e_snp(ST_CMT, 32'hD400_0004), "R6");
    go(s_rd(8'h10, 32'hFFFF_FFFF), e_rsp(ST_CMT, 32'hC100_0010), "R5");
    go(s_rd(8'h11, 32'hF100_0011), e_rsp(ST_CMT, 32'hF100_0011), "R9");
    go(s_cmt(), e_no(ST_CMT), "R11");
    go(s_abt(), e_no(ST_CMT), "R11");

    // transaction 2: abort strobe
    go(s_beg(), e_no(ST_ACT), "R4");
    go(s_rd(8'h10, 32'hFFFF_FFFF), e_rsp(ST_ACT, 32'hC100_0010), "R7");
    go(s_wr(8'h14, 32'hD500_0005), e_no(ST_ACT), "R7");
    go(s_beg(), e_no(ST_ACT), "R11");
    go(s_abt(), e_no(ST_ABT), "R7");
    go(s_rd(8'h14, 32'hA500_0014), e_rsp(ST_ABT, 32'hA500_0014), "R7");
    go(s_rd(8'h10, 32'hFFFF_FFFF), e_rsp(ST_ABT, 32'hC100_0010), "R7");

    // transaction 3: snoop conflict with a request in the same cycle
    go(s_beg(), e_no(ST_ACT), "R4");
    go(s_wr(8'h10, 32'hD600_0006), e_no(ST_ACT), "R8");
    go(s_rd(8'h15, 32'hB500_0015), e_rsp(ST_ACT, 32'hB500_0015), "R8");
    go(stim_t'(s_snp(8'h10) | s_rd(8'h16, 32'h1111_1111)), e_no(ST_ABT), "R8");
    go(s_rd(8'h10, 32'hA000_0010), e_rsp(ST_ABT, 32'hA000_0010), "R8");
    go(s_rd(8'h15, 32'hFFFF_FFFF), e_rsp(ST_ABT, 32'hB500_0015), "R7");
    go(s_rd(8'h1E, 32'hC600_001E), e_rsp(ST_ABT, 32'hC600_001E), "R10");
    go(s_rd(8'h16, 32'hC600_0016), e_rsp(ST_ABT, 32'hC600_0016), "R10");

    // transaction 4: eviction of a tagged line
    go(s_beg(), e_no(ST_ACT), "R4");
    go(s_rd(8'h15, 32'hFFFF_FFFF), e_rsp(ST_ACT, 32'hB500_0015), "R10");
    go(s_rd(8'h1D, 32'h2222_2222), e_no(ST_ABT), "R10");
    go(s_rd(8'h15, 32'hFFFF_FFFF), e_rsp(ST_ABT, 32'hB500_0015), "R10");

    // transaction 5: commit and abort together
    go(s_beg(), e_no(ST_ACT), "R4");
    go(s_wr(8'h17, 32'hD700_0007), e_no(ST_ACT), "R11");
    go(stim_t'(s_cmt() | s_abt()), e_no(ST_ABT), "R11");
    go(s_rd(8'h17, 32'hA700_0017), e_rsp(ST_ABT, 32'hA700_0017), "R11");

    // transaction 6: snoop hits a dirty line that was only read
    go(s_wr(8'h12, 32'hD800_0008), e_no(ST_ABT), "R3");
    go(s_beg(), e_no(ST_ACT), "R4");
    go(s_rd(8'h12, 32'hFFFF_FFFF), e_rsp(ST_ACT, 32'hD800_0008), "R8");
    go(s_snp(8'h12), e_snp(ST_ABT, 32'hD800_0008), "R8");
    go(s_rd(8'h12, 32'hA800_0012), e_rsp(ST_ABT, 32'hA800_0012), "R8");
    go(s0(), e_no(ST_ABT), "R11");

    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule